// File: doc/BRIEF.md
# Multi-Channel Linked-Block Buffer

This block is a shared dword store for up to 40 channels. The store is cut into 512 blocks of four 32-bit dwords each, 8 KB in all. None of that space is set aside for a given channel. The host owns the layout. It writes a next-block table that links blocks into closed rings. It gives each channel an entry block that may be any member of the channel's ring, and it sets the ring length in blocks. After that the host enables the channel.

A producer pushes dwords with a channel number. A consumer pops dwords with a channel number and gets them back one clock later. Each channel keeps its own write position, read position and dword occupancy count. When a position leaves the last dword of a block, the next-block table decides which block comes next. A registered empty flag and a registered full flag for each channel show where every channel stands. A request the block cannot carry out is dropped and flagged for one cycle.

Top module: `chain_fifo`

## Requirements
- R1: After reset every channel is disabled, `ch_empty` is all ones, `ch_full` is all zeros, and `cfg_err`, `wr_drop`, `rd_drop` and `rd_valid` are 0.
- R2: Configuration uses `cfg_kind`. Kind 0 writes `cfg_data[8:0]` as the next block of block `cfg_idx`. Kind 1 writes the entry block of channel `cfg_idx`. Kind 2 writes the ring length in blocks of channel `cfg_idx`. Kind 3 with `cfg_data[0]`=1 enables channel `cfg_idx`, which also sets both positions to dword 0 of the entry block and empties the channel. This holds even when the channel already holds data.
- R3: An enable whose length is outside 4..512 pulses `cfg_err` in the following cycle and leaves the channel disabled. Later writes to that channel are dropped.
- R4: Dwords come out of a channel in the order they went in. `rd_data` and `rd_valid` show the result in the cycle after an accepted pop.
- R5: After dword 3 of a block, a position moves to dword 0 of the block named by the next-block table. Rings stay closed, so a channel can be cycled through many times its capacity and keep its order.
- R6: A channel is full when its count equals 4 × its length. A write to a full channel is not stored and sets `wr_drop` in the next cycle.
- R7: A pop from an empty or disabled channel returns nothing. It sets `rd_drop`, and `rd_valid` stays low, in the next cycle.
- R8: A write and a pop on the same channel in the same cycle leave its count, and so its empty and full flags, unchanged.
- R9: Channels whose rings do not share blocks keep independent contents, whichever block each one enters at.
- R10: Kind 3 with `cfg_data[0]`=0 disables a channel. It then reads as empty and drops writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Configuration target (see R2) |
| cfg_idx | input | 9 | Block or channel index |
| cfg_data | input | 10 | Configuration value |
| cfg_err | output | 1 | Illegal ring length on enable |
| wr_en | input | 1 | Write request |
| wr_ch | input | 6 | Write channel |
| wr_data | input | 32 | Write dword |
| wr_drop | output | 1 | Previous write was dropped |
| rd_en | input | 1 | Pop request |
| rd_ch | input | 6 | Pop channel |
| rd_data | output | 32 | Popped dword |
| rd_valid | output | 1 | `rd_data` holds a popped dword |
| rd_drop | output | 1 | Previous pop was dropped |
| ch_empty | output | 40 | Per-channel empty flags |
| ch_full | output | 40 | Per-channel full flags |

## Verification
On every cycle, the assertions check the following:
- a write to a channel flagged full is reported as dropped;
- a pop from a channel flagged empty is dropped and carries no data;
- a pop from a non-empty channel yields valid data one cycle later;
- no channel is flagged empty and full at once;
- the occupancy count stays within the ring's capacity;
- an illegal enable leaves the channel disabled.

Only the bench scenarios can show the rest:
- that the data returns in order;
- that the next-block table is really followed around a ring entered partway along;
- that two rings stay separate;
- what happens on re-enable and disable.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;
  typedef enum logic [1:0] {
    CFG_NEXT  = 2'd0,
    CFG_START = 2'd1,
    CFG_LEN   = 2'd2,
    CFG_CTRL  = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/chain_fifo_ptr_ram.sv
module chain_fifo_ptr_ram #(
  parameter int NUM_BLK = 512,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [BLK_W-1:0] waddr,
  input  logic [BLK_W-1:0] wdata,
  input  logic [BLK_W-1:0] ra_addr,
  output logic [BLK_W-1:0] ra_data,
  input  logic [BLK_W-1:0] rb_addr,
  output logic [BLK_W-1:0] rb_data
);
  logic [BLK_W-1:0] mem [NUM_BLK];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/chain_fifo_data_ram.sv
module chain_fifo_data_ram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/chain_fifo_chan.sv
module chain_fifo_chan #(
  parameter int NUM_BLK   = 512,
  parameter int BLK_DW    = 4,
  parameter int MIN_CHAIN = 4,
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int DW_W     = $clog2(BLK_DW),
  localparam int LEN_W    = $clog2(NUM_BLK + 1),
  localparam int CNT_W    = $clog2(NUM_BLK * BLK_DW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_we,
  input  logic             len_we,
  input  logic             ctrl_we,
  input  logic             ctrl_on,
  input  logic [LEN_W-1:0] cfg_val,
  input  logic             push,
  input  logic             pop,
  input  logic [BLK_W-1:0] wnext_blk,
  input  logic [BLK_W-1:0] rnext_blk,
  output logic             cfg_bad,
  output logic             en_o,
  output logic [BLK_W-1:0] wblk_o,
  output logic [DW_W-1:0]  wdw_o,
  output logic [BLK_W-1:0] rblk_o,
  output logic [DW_W-1:0]  rdw_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [DW_W-1:0] LAST_DW = DW_W'(BLK_DW - 1);

  logic [BLK_W-1:0] start_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q, cap_q, cnt_nx;
  logic             legal;

  assign legal   = (len_q >= LEN_W'(MIN_CHAIN)) && (len_q <= LEN_W'(NUM_BLK));
  assign cfg_bad = ctrl_we && ctrl_on && !legal;
  assign cnt_nx  = cnt_q + CNT_W'(push) - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      cap_q   <= '0;
      en_o    <= 1'b0;
      wblk_o  <= '0;
      wdw_o   <= '0;
      rblk_o  <= '0;
      rdw_o   <= '0;
      empty_o <= 1'b1;
      full_o  <= 1'b0;
    end else begin
      if (start_we) start_q <= cfg_val[BLK_W-1:0];
      if (len_we)   len_q   <= cfg_val;
      if (ctrl_we) begin
        en_o    <= ctrl_on && legal;
        wblk_o  <= start_q;
        rblk_o  <= start_q;
        wdw_o   <= '0;
        rdw_o   <= '0;
        cnt_q   <= '0;
        cap_q   <= CNT_W'(len_q) << DW_W;
        empty_o <= 1'b1;
        full_o  <= 1'b0;
      end else begin
        if (push) begin
          if (wdw_o == LAST_DW) begin
            wdw_o  <= '0;
            wblk_o <= wnext_blk;
          end else begin
            wdw_o <= wdw_o + 1'b1;
          end
        end
        if (pop) begin
          if (rdw_o == LAST_DW) begin
            rdw_o  <= '0;
            rblk_o <= rnext_blk;
          end else begin
            rdw_o <= rdw_o + 1'b1;
          end
        end
        cnt_q   <= cnt_nx;
        empty_o <= (cnt_nx == '0);
        full_o  <= en_o && (cnt_nx == cap_q);
      end
    end
  end

  // R6
  cap_chk: assert property (@(posedge clk) disable iff (rst)
    en_o |-> (cnt_q <= cap_q));

  // R3
  bad_en_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> !en_o);

  // R8
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !ctrl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo
  import chain_fifo_pkg::*;
#(
  parameter int NUM_CH    = 40,
  parameter int NUM_BLK   = 512,
  parameter int BLK_DW    = 4,
  parameter int DATA_W    = 32,
  parameter int MIN_CHAIN = 4,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int DW_W     = $clog2(BLK_DW),
  localparam int LEN_W    = $clog2(NUM_BLK + 1),
  localparam int IDX_W    = (BLK_W > CH_W) ? BLK_W : CH_W,
  localparam int ADDR_W   = BLK_W + DW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [LEN_W-1:0]  cfg_data,
  output logic              cfg_err,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_drop,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_drop,
  output logic [NUM_CH-1:0] ch_empty,
  output logic [NUM_CH-1:0] ch_full
);
  logic [BLK_W-1:0] wblk_a [NUM_CH];
  logic [BLK_W-1:0] rblk_a [NUM_CH];
  logic [DW_W-1:0]  wdw_a  [NUM_CH];
  logic [DW_W-1:0]  rdw_a  [NUM_CH];
  logic [NUM_CH-1:0] en_v, bad_v;
  logic [BLK_W-1:0] wnext, rnext;
  logic [CH_W-1:0]  wix, rix;
  logic             wch_ok, rch_ok, push, pop;

  assign wch_ok = (32'(wr_ch) < NUM_CH);
  assign rch_ok = (32'(rd_ch) < NUM_CH);
  assign wix    = wch_ok ? wr_ch : '0;
  assign rix    = rch_ok ? rd_ch : '0;
  assign push   = wr_en && wch_ok && en_v[wix] && !ch_full[wix];
  assign pop    = rd_en && rch_ok && !ch_empty[rix];

  chain_fifo_ptr_ram #(.NUM_BLK(NUM_BLK)) u_ptr (
    .clk     (clk),
    .we      (cfg_we && cfg_kind == CFG_NEXT),
    .waddr   (cfg_idx[BLK_W-1:0]),
    .wdata   (cfg_data[BLK_W-1:0]),
    .ra_addr (wblk_a[wix]),
    .ra_data (wnext),
    .rb_addr (rblk_a[rix]),
    .rb_data (rnext)
  );

  chain_fifo_data_ram #(.DEPTH(NUM_BLK * BLK_DW), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .we    (push),
    .waddr (ADDR_W'({wblk_a[wix], wdw_a[wix]})),
    .wdata (wr_data),
    .raddr (ADDR_W'({rblk_a[rix], rdw_a[rix]})),
    .rdata (rd_data)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = cfg_we && (cfg_idx == IDX_W'(i));
    chain_fifo_chan #(
      .NUM_BLK(NUM_BLK), .BLK_DW(BLK_DW), .MIN_CHAIN(MIN_CHAIN)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .start_we  (sel && cfg_kind == CFG_START),
      .len_we    (sel && cfg_kind == CFG_LEN),
      .ctrl_we   (sel && cfg_kind == CFG_CTRL),
      .ctrl_on   (cfg_data[0]),
      .cfg_val   (cfg_data),
      .push      (push && wix == CH_W'(i)),
      .pop       (pop && rix == CH_W'(i)),
      .wnext_blk (wnext),
      .rnext_blk (rnext),
      .cfg_bad   (bad_v[i]),
      .en_o      (en_v[i]),
      .wblk_o    (wblk_a[i]),
      .wdw_o     (wdw_a[i]),
      .rblk_o    (rblk_a[i]),
      .rdw_o     (rdw_a[i]),
      .empty_o   (ch_empty[i]),
      .full_o    (ch_full[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err  <= 1'b0;
      wr_drop  <= 1'b0;
      rd_drop  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      cfg_err  <= |bad_v;
      wr_drop  <= wr_en && !push;
      rd_drop  <= rd_en && !pop;
      rd_valid <= pop;
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wch_ok && ch_full[wix]) |=> wr_drop);

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rch_ok && ch_empty[rix]) |=> (rd_drop && !rd_valid));

  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rch_ok && !ch_empty[rix]) |=> rd_valid);

  // R1
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_empty & ch_full) == '0);
endmodule

// File: tb/chain_fifo_bench.sv
module chain_fifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [8:0]  cfg_idx = '0;
  logic [9:0]  cfg_data = '0;
  logic        cfg_err;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_ch = '0;
  logic [31:0] wr_data = '0;
  logic        wr_drop;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_ch = '0;
  logic [31:0] rd_data;
  logic        rd_valid, rd_drop;
  logic [39:0] ch_empty, ch_full;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chain_fifo u_chain_fifo (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] k, input int idx, input int d);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = 9'(idx); cfg_data = 10'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one cycle with optional write and pop; outputs sampled after the edge
  task automatic op(input bit we, input int wc, input logic [31:0] wd,
                    input bit re, input int rc);
    wr_en = we; wr_ch = 6'(wc); wr_data = wd;
    rd_en = re; rd_ch = 6'(rc);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input int ch, input logic [31:0] d, input bit drop, input string req);
    op(1'b1, ch, d, 1'b0, 0);
    chk(wr_drop == drop, req, "wr_drop", wr_drop, drop);
  endtask

  task automatic rd(input int ch, input bit ok, input logic [31:0] d, input string req);
    op(1'b0, 0, '0, 1'b1, ch);
    chk(rd_valid == ok && rd_drop == !ok, req, "rd_valid", rd_valid, ok);
    if (ok) chk(rd_data == d, req, "rd_data", rd_data, d);
  endtask

  task automatic ring(input int ch, input int first, input int nblk, input int entry);
    for (int b = 0; b < nblk; b++)
      cfg(2'd0, first + b, first + ((b + 1) % nblk));
    cfg(2'd1, ch, entry);
    cfg(2'd2, ch, nblk);
  endtask

  task automatic t_reset();
    chk(ch_empty == '1, "R1", "ch_empty", ch_empty, 40'hFF_FFFF_FFFF);
    chk(ch_full == '0, "R1", "ch_full", ch_full, 0);
    chk({cfg_err, wr_drop, rd_drop, rd_valid} == 4'b0, "R1", "flags",
        {cfg_err, wr_drop, rd_drop, rd_valid}, 0);
  endtask

  task automatic t_bad_len();
    cfg(2'd2, 5, 3);
    cfg(2'd3, 5, 1);
    chk(cfg_err == 1'b1, "R3", "cfg_err len3", cfg_err, 1);
    wr(5, 32'h55, 1'b1, "R3");
    cfg(2'd2, 5, 513);
    cfg(2'd3, 5, 1);
    chk(cfg_err == 1'b1, "R3", "cfg_err len513", cfg_err, 1);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R3", "cfg_err pulse", cfg_err, 0);
    wr(5, 32'h56, 1'b1, "R3");
  endtask

  task automatic t_fill_drain();
    ring(3, 10, 4, 12);
    ring(7, 20, 5, 22);
    cfg(2'd3, 3, 1);
    cfg(2'd3, 7, 1);
    chk(cfg_err == 1'b0 && ch_empty[3] && ch_empty[7], "R2", "enable empty",
        {cfg_err, ch_empty[3], ch_empty[7]}, 3'b011);
    rd(3, 1'b0, '0, "R7");
    for (int i = 0; i < 20; i++) begin
      if (i < 16) wr(3, 32'h300 + i, 1'b0, "R6");
      wr(7, 32'h700 + i, 1'b0, "R9");
    end
    chk(ch_full[3] && ch_full[7], "R6", "full", {ch_full[3], ch_full[7]}, 2'b11);
    wr(3, 32'hDEAD, 1'b1, "R6");
    chk(ch_full[3] == 1'b1, "R6", "still full", ch_full[3], 1);
    for (int i = 0; i < 16; i++) rd(3, 1'b1, 32'h300 + i, "R5");
    chk(ch_empty[3] == 1'b1, "R4", "drained", ch_empty[3], 1);
    rd(3, 1'b0, '0, "R7");
    for (int i = 0; i < 20; i++) rd(7, 1'b1, 32'h700 + i, "R9");
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 10; i++) wr(3, 32'h3000 + r * 16 + i, 1'b0, "R5");
      for (int i = 0; i < 10; i++) rd(3, 1'b1, 32'h3000 + r * 16 + i, "R5");
    end
  endtask

  task automatic t_same_cycle();
    wr(7, 32'hA0, 1'b0, "R8");
    op(1'b1, 7, 32'hA1, 1'b1, 7);
    chk(rd_valid && rd_data == 32'hA0, "R8", "data A0", rd_data, 32'hA0);
    chk(!ch_empty[7] && !ch_full[7], "R8", "flags kept", {ch_empty[7], ch_full[7]}, 0);
    op(1'b1, 7, 32'hA2, 1'b1, 7);
    chk(rd_valid && rd_data == 32'hA1, "R8", "data A1", rd_data, 32'hA1);
    rd(7, 1'b1, 32'hA2, "R8");
    chk(ch_empty[7] == 1'b1, "R8", "empty after", ch_empty[7], 1);
  endtask

  task automatic t_reenable_disable();
    wr(3, 32'hB0, 1'b0, "R2");
    cfg(2'd3, 3, 1);
    chk(ch_empty[3] == 1'b1, "R2", "re-enable empties", ch_empty[3], 1);
    rd(3, 1'b0, '0, "R2");
    wr(3, 32'hB1, 1'b0, "R2");
    rd(3, 1'b1, 32'hB1, "R2");
    wr(7, 32'hC0, 1'b0, "R10");
    cfg(2'd3, 7, 0);
    chk(ch_empty[7] == 1'b1, "R10", "disabled empty", ch_empty[7], 1);
    wr(7, 32'hC1, 1'b1, "R10");
    rd(7, 1'b0, '0, "R10");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bad_len();
    t_fill_drain();
    t_wrap();
    t_same_cycle();
    t_reenable_disable();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      report();
    end
  end
endmodule